// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel audio words into a serial bit stream. Timing comes from outside the block. A one-cycle `bit_tick` strobe marks each active bit-clock edge, and `fsync` is sampled on those ticks to mark the start of a frame. A frame has one or two phases. Each phase has its own word count and its own word length, taken from a packed control word.

Words enter through a single holding register with a valid/ready handshake. A word is accepted on any clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high exactly when the holding register is empty. The source may hold `s_valid` high for as long as it likes and may change `s_data` while `s_ready` is low. When the sequencer needs a word, it moves the held word into the shift register, and `s_ready` returns high in the next cycle. If no word is held at that moment, the previously sent word is sent again.

A sync that arrives while a frame is still shifting either restarts the frame and latches `sync_err`, or has no effect at all, depending on a control bit. Dropping `tx_en` halts shifting and clears the error.

Top module: `sfx_frame_tx`

## Requirements
- R1: The word-length code maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5 (or above)→32 bits. For a length L, the low L bits of the word go out most significant bit first, one bit per tick.
- R2: When `ctrl_word[20]` is clear, a frame is `ctrl_word[9:3]`+1 words, each of the length coded in `ctrl_word[2:0]`. The phase-2 fields are ignored.
- R3: When `ctrl_word[20]` is set, phase 1 is followed by `ctrl_word[19:13]`+1 words, each of the length coded in `ctrl_word[12:10]`.
- R4: With `ctrl_word[21]` clear, the first data bit appears on the sync tick. With it set, the sync tick drives 0 and the first data bit follows one tick later.
- R5: With `ctrl_word[22]` clear, a sync on any tick of an active frame (up to and including the last data bit) sets `sync_err`. The error stays latched, and the frame restarts from that sync.
- R6: With `ctrl_word[22]` set, a sync during an active frame has no effect on `sdata` or `sync_err`.
- R7: A sync on the first tick after the last data bit starts the next frame without an error.
- R8: If the holding register is empty when a word is due, the last word sent is sent again.
- R9: `s_ready` is low while a word is held. It returns high the cycle after that word is loaded for shifting.
- R10: While `tx_en` is low, `sdata` and `sync_err` are 0 from the next cycle on, syncs are ignored, and a held word stays held.
- R11: `sdata` changes only on a tick or on disable. A tick outside a frame drives 0.
- R12: After reset, `s_ready` is 1 and `sdata` and `sync_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low holds the transmitter in reset and clears the error |
| ctrl_word | input | 23 | Frame configuration, field layout as in R2 to R6 |
| bit_tick | input | 1 | One-cycle strobe per active bit-clock edge |
| fsync | input | 1 | Frame sync, sampled on ticks |
| s_valid | input | 1 | Word offered |
| s_data | input | 32 | Word, right-justified |
| s_ready | output | 1 | Holding register empty |
| sdata | output | 1 | Serial data |
| sync_err | output | 1 | Latched unexpected-sync flag |

## Verification
The hardest case to reach from the ports is a non-ignored sync in mid-frame. It has to show both that the error latches and that the frame really restarts, rather than running on to its old end. The stimulus fills a four-word frame with all-ones words and fires a second sync a few bits in. It then counts exactly 32 ones from the restart, followed by an idle 0. A frame that simply continued would have dropped to 0 several ticks earlier. A sweep over all six word lengths, both delays and both phase modes runs frames back to back, so every frame boundary also tests that a sync right after the last bit is legal.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int unsigned SFX_DATA_W = 32;
  localparam int unsigned SFX_FLEN_W = 7;
  localparam int unsigned SFX_CNT_W  = $clog2(SFX_DATA_W + 1);
  localparam int unsigned SFX_WL_W   = 3;

  // packed control layout, low to high
  localparam int unsigned SFX_WL1_POS  = 0;
  localparam int unsigned SFX_FL1_POS  = SFX_WL1_POS + SFX_WL_W;
  localparam int unsigned SFX_WL2_POS  = SFX_FL1_POS + SFX_FLEN_W;
  localparam int unsigned SFX_FL2_POS  = SFX_WL2_POS + SFX_WL_W;
  localparam int unsigned SFX_DUAL_POS = SFX_FL2_POS + SFX_FLEN_W;
  localparam int unsigned SFX_DLY_POS  = SFX_DUAL_POS + 1;
  localparam int unsigned SFX_IGN_POS  = SFX_DLY_POS + 1;
  localparam int unsigned SFX_CTRL_W   = SFX_IGN_POS + 1;

  typedef struct packed {
    logic                  dual;
    logic                  ign_sync;
    logic                  delay1;
    logic [SFX_WL_W-1:0]   wl_p1;
    logic [SFX_WL_W-1:0]   wl_p2;
    logic [SFX_FLEN_W-1:0] fl_p1;
    logic [SFX_FLEN_W-1:0] fl_p2;
  } sfx_cfg_t;

  function automatic logic [SFX_CNT_W-1:0] sfx_word_bits(input logic [SFX_WL_W-1:0] code);
    logic [SFX_CNT_W-1:0] n;
    case (code)
      3'd0:    n = SFX_CNT_W'(8);
      3'd1:    n = SFX_CNT_W'(12);
      3'd2:    n = SFX_CNT_W'(16);
      3'd3:    n = SFX_CNT_W'(20);
      3'd4:    n = SFX_CNT_W'(24);
      default: n = SFX_CNT_W'(32);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sfx_ctrl_decode.sv
module sfx_ctrl_decode
  import sfx_pkg::*;
(
  input  logic [SFX_CTRL_W-1:0] ctrl_word,
  output sfx_cfg_t              cfg
);
  assign cfg.wl_p1    = ctrl_word[SFX_WL1_POS +: SFX_WL_W];
  assign cfg.fl_p1    = ctrl_word[SFX_FL1_POS +: SFX_FLEN_W];
  assign cfg.wl_p2    = ctrl_word[SFX_WL2_POS +: SFX_WL_W];
  assign cfg.fl_p2    = ctrl_word[SFX_FL2_POS +: SFX_FLEN_W];
  assign cfg.dual     = ctrl_word[SFX_DUAL_POS];
  assign cfg.delay1   = ctrl_word[SFX_DLY_POS];
  assign cfg.ign_sync = ctrl_word[SFX_IGN_POS];
endmodule

// File: rtl/sfx_hold_reg.sv
module sfx_hold_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              take,
  output logic [DATA_W-1:0] word_out
);
  logic              full_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] last_q;

  assign s_ready  = !full_q;
  // underrun: the last word handed out is offered again
  assign word_out = full_q ? hold_q : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
      last_q <= '0;
    end else begin
      if (take) last_q <= word_out;
      if (s_valid && !full_q) begin
        hold_q <= s_data;
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_zero,
  input  logic              op_load,
  input  logic              op_shift,
  input  logic [DATA_W-1:0] word,
  input  logic [CNT_W-1:0]  len,
  output logic              sdata
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  lsh;

  // left-justify the word so its top valid bit sits at the MSB
  assign lsh   = CNT_W'(DATA_W) - len;
  assign sdata = sh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (op_zero)  sh_q <= '0;
    else if (op_load)  sh_q <= word << lsh;
    else if (op_shift) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/sfx_frame_seq.sv
module sfx_frame_seq
  import sfx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 bit_tick,
  input  logic                 fsync,
  input  sfx_cfg_t             cfg,
  output logic                 op_zero,
  output logic                 op_load,
  output logic                 op_shift,
  output logic [SFX_CNT_W-1:0] load_len,
  output logic                 sync_err
);
  logic                  active_q;
  logic                  need_load_q;
  logic                  phase_q;
  logic [SFX_FLEN_W-1:0] word_cnt_q;
  logic [SFX_CNT_W-1:0]  bits_rem_q;

  logic [SFX_CNT_W-1:0]  len1, len2, cur_len;
  logic                  tick_en, start, cont, sync_mid, last_of_phase;

  assign len1    = sfx_word_bits(cfg.wl_p1);
  assign len2    = sfx_word_bits(cfg.wl_p2);
  assign cur_len = phase_q ? len2 : len1;

  assign tick_en  = tx_en && bit_tick;
  assign sync_mid = tick_en && fsync && active_q;
  // a sync starts a frame when idle, or restarts one when not ignored
  assign start    = tick_en && fsync && (!active_q || !cfg.ign_sync);
  assign cont     = tick_en && active_q && !start;
  assign last_of_phase = (word_cnt_q == (phase_q ? cfg.fl_p2 : cfg.fl_p1));

  assign load_len = start ? len1 : cur_len;
  assign op_load  = start ? !cfg.delay1 : (cont && need_load_q);
  assign op_shift = cont && !need_load_q;
  assign op_zero  = !tx_en || (start && cfg.delay1) || (tick_en && !active_q && !start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      need_load_q <= 1'b0;
      phase_q     <= 1'b0;
      word_cnt_q  <= '0;
      bits_rem_q  <= '0;
      sync_err    <= 1'b0;
    end else if (!tx_en) begin
      active_q    <= 1'b0;
      need_load_q <= 1'b0;
      phase_q     <= 1'b0;
      word_cnt_q  <= '0;
      bits_rem_q  <= '0;
      sync_err    <= 1'b0;
    end else begin
      if (sync_mid && !cfg.ign_sync) sync_err <= 1'b1;
      if (start) begin
        active_q   <= 1'b1;
        phase_q    <= 1'b0;
        word_cnt_q <= '0;
        if (cfg.delay1) begin
          need_load_q <= 1'b1;
          bits_rem_q  <= '0;
        end else begin
          need_load_q <= 1'b0;
          bits_rem_q  <= len1 - 1'b1;
        end
      end else if (cont) begin
        if (need_load_q) begin
          need_load_q <= 1'b0;
          bits_rem_q  <= cur_len - 1'b1;
        end else if (bits_rem_q != SFX_CNT_W'(1)) begin
          bits_rem_q <= bits_rem_q - 1'b1;
        end else begin
          // this tick put out the final bit of the current word
          bits_rem_q <= '0;
          if (!last_of_phase) begin
            word_cnt_q  <= word_cnt_q + 1'b1;
            need_load_q <= 1'b1;
          end else if (!phase_q && cfg.dual) begin
            phase_q     <= 1'b1;
            word_cnt_q  <= '0;
            need_load_q <= 1'b1;
          end else begin
            active_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfx_frame_tx.sv
module sfx_frame_tx
  import sfx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_en,
  input  logic [SFX_CTRL_W-1:0] ctrl_word,
  input  logic                  bit_tick,
  input  logic                  fsync,
  input  logic                  s_valid,
  input  logic [SFX_DATA_W-1:0] s_data,
  output logic                  s_ready,
  output logic                  sdata,
  output logic                  sync_err
);
  sfx_cfg_t              cfg;
  logic                  op_zero, load_word, op_shift;
  logic [SFX_CNT_W-1:0]  load_len;
  logic [SFX_DATA_W-1:0] next_word;

  sfx_ctrl_decode u_dec (
    .ctrl_word (ctrl_word),
    .cfg       (cfg)
  );

  sfx_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .bit_tick (bit_tick),
    .fsync    (fsync),
    .cfg      (cfg),
    .op_zero  (op_zero),
    .op_load  (load_word),
    .op_shift (op_shift),
    .load_len (load_len),
    .sync_err (sync_err)
  );

  sfx_hold_reg #(.DATA_W(SFX_DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .s_ready  (s_ready),
    .take     (load_word),
    .word_out (next_word)
  );

  sfx_shifter #(.DATA_W(SFX_DATA_W), .CNT_W(SFX_CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_zero  (op_zero),
    .op_load  (load_word),
    .op_shift (op_shift),
    .word     (next_word),
    .len      (load_len),
    .sdata    (sdata)
  );
endmodule

// File: rtl/sfx_frame_tx_chk.sv
module sfx_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic ign_sync,
  input logic bit_tick,
  input logic fsync,
  input logic s_valid,
  input logic s_ready,
  input logic sdata,
  input logic sync_err,
  input logic load_word
);
  // R5
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> $past(tx_en && bit_tick && fsync));

  // R6
  ign_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && bit_tick && fsync && ign_sync && !sync_err) |=> !sync_err);

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!sync_err && !sdata));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !bit_tick) |=> $stable(sdata));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !load_word) |=> !s_ready);

  // R9
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_word && !s_valid) |=> s_ready);
endmodule

bind sfx_frame_tx sfx_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .ign_sync  (ctrl_word[sfx_pkg::SFX_IGN_POS]),
  .bit_tick  (bit_tick),
  .fsync     (fsync),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .sdata     (sdata),
  .sync_err  (sync_err),
  .load_word (load_word)
);

// File: tb/sfx_frame_tx_bench.sv
module sfx_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [22:0] ctrl_word = '0;
  logic        bit_tick = 1'b0;
  logic        fsync = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, sdata, sync_err;

  sfx_frame_tx u_sfx_frame_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ctrl_word(ctrl_word),
    .bit_tick(bit_tick), .fsync(fsync), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .sdata(sdata), .sync_err(sync_err)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [31:0] feed_q [0:255];
  int          feed_wr = 0;
  int          feed_rd = 0;
  logic [31:0] frame_words [0:15];
  logic [31:0] last_sent = '0;
  logic        exp_bits [0:1023];
  int          first_bad = 0;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog R11: actual hung run, expected completion");
    report();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int wbits(input int c);
    return (c < 5) ? 8 + 4 * c : 32;
  endfunction

  function automatic logic [22:0] mk_ctrl(input int c1, input int f1, input int c2,
                                          input int f2, input bit du, input bit dl,
                                          input bit ig);
    logic [22:0] v;
    v = '0;
    v[2:0]   = c1[2:0];
    v[9:3]   = f1[6:0];
    v[12:10] = c2[2:0];
    v[19:13] = f2[6:0];
    v[20]    = du;
    v[21]    = dl;
    v[22]    = ig;
    return v;
  endfunction

  task automatic push(input logic [31:0] w);
    feed_q[feed_wr] = w;
    feed_wr++;
  endtask

  // called at a falling edge; offers one queued word if the holding register is empty
  task automatic feed();
    if (s_ready && feed_rd < feed_wr) begin
      s_valid = 1'b1;
      s_data  = feed_q[feed_rd];
      feed_rd++;
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  task automatic tick(input logic fs, output logic b);
    bit_tick = 1'b1;
    fsync    = fs;
    @(negedge clk);
    bit_tick = 1'b0;
    fsync    = 1'b0;
    b        = sdata;
    feed();
    @(negedge clk);
  endtask

  task automatic run_frame(input int c1, input int f1, input int c2, input int f2,
                           input bit du, input bit dl, input bit ig,
                           input int npush, input int mid_at, output int mism);
    int nexp;
    int nw;
    logic [31:0] w;
    nexp = 0;
    ctrl_word = mk_ctrl(c1, f1, c2, f2, du, dl, ig);
    nw = f1 + 1 + (du ? f2 + 1 : 0);
    for (int k = 0; k < npush; k++) push(frame_words[k]);
    feed();
    for (int k = 0; k < nw; k++) begin
      int len;
      len = (du && k > f1) ? wbits(c2) : wbits(c1);
      w = (k < npush) ? frame_words[k] : last_sent;
      last_sent = w;
      for (int b = len - 1; b >= 0; b--) begin
        exp_bits[nexp] = w[b];
        nexp++;
      end
    end
    mism = 0;
    for (int t = 0; t < nexp + int'(dl); t++) begin
      logic got, want;
      tick((t == 0) || (t == mid_at), got);
      want = (t < int'(dl)) ? 1'b0 : exp_bits[t - int'(dl)];
      if (got !== want) begin
        if (mism == 0) first_bad = t;
        mism++;
      end
    end
  endtask

  initial begin
    logic b;
    logic [31:0] acc;
    int mism;
    int idx;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(s_ready == 1'b1, "R12", "s_ready after reset", 32'(s_ready), 32'd1);
    chk(sdata == 1'b0, "R12", "sdata after reset", 32'(sdata), 32'd0);
    chk(sync_err == 1'b0, "R12", "sync_err after reset", 32'(sync_err), 32'd0);

    // R9 handshake, R10 disabled: 8-bit single phase, phase-2 fields set to junk
    ctrl_word = mk_ctrl(0, 0, 5, 3, 1'b0, 1'b0, 1'b0);
    push(32'h0000_00C3);
    feed();
    chk(s_ready == 1'b0, "R9", "s_ready with word held", 32'(s_ready), 32'd0);
    tick(1'b1, b);
    chk(b == 1'b0 && s_ready == 1'b0, "R10", "sync while disabled (sdata,ready)",
        {30'd0, b, s_ready}, 32'd0);
    tx_en = 1'b1;
    @(negedge clk);
    acc = '0;
    tick(1'b1, b);
    acc = {acc[30:0], b};
    chk(s_ready == 1'b1, "R9", "s_ready after load", 32'(s_ready), 32'd1);
    for (int i = 0; i < 7; i++) begin
      tick(1'b0, b);
      acc = {acc[30:0], b};
    end
    chk(acc == 32'h0000_00C3, "R1", "8-bit word MSB first", acc, 32'h0000_00C3);
    last_sent = 32'h0000_00C3;
    tick(1'b0, b);
    chk(b == 1'b0, "R11", "idle tick after frame", 32'(b), 32'd0);

    // sweep: all lengths, both delays, both phase modes, back to back (R1 R2 R3 R4 R7)
    idx = 0;
    for (int c1 = 0; c1 < 6; c1++) begin
      for (int dl = 0; dl < 2; dl++) begin
        for (int du = 0; du < 2; du++) begin
          for (int k = 0; k < 8; k++)
            frame_words[k] = (32'h9E37_79B9 * 32'(idx * 7 + k + 1)) ^ 32'h5A5A_3C3C;
          run_frame(c1, (c1 + dl) % 2, (c1 + 3) % 6, (c1 + du) % 3, du[0], dl[0], 1'b0,
                    ((c1 + dl) % 2) + 1 + (du != 0 ? ((c1 + du) % 3) + 1 : 0), -1, mism);
          chk(mism == 0, "R1 R2 R3 R4", $sformatf("frame c1=%0d dl=%0d du=%0d bad tick", c1, dl, du),
              32'(first_bad), 32'hFFFF_FFFF);
          chk(sync_err == 1'b0, "R7", "back-to-back sync error flag", 32'(sync_err), 32'd0);
          idx++;
        end
      end
    end
    tick(1'b0, b);
    chk(b == 1'b0, "R11", "idle tick after sweep", 32'(b), 32'd0);

    // R6 ignored mid-frame sync
    frame_words[0] = 32'h0000_A1B2;
    frame_words[1] = 32'h0000_3C4D;
    run_frame(2, 1, 0, 0, 1'b0, 1'b0, 1'b1, 2, 7, mism);
    chk(mism == 0, "R6", "ignored mid-frame sync, bad tick", 32'(first_bad), 32'hFFFF_FFFF);
    chk(sync_err == 1'b0, "R6", "sync_err after ignored sync", 32'(sync_err), 32'd0);

    // R8 underrun within a frame and across frames
    frame_words[0] = 32'h0000_0096;
    run_frame(0, 2, 0, 0, 1'b0, 1'b0, 1'b0, 1, -1, mism);
    chk(mism == 0, "R8", "repeat within frame, bad tick", 32'(first_bad), 32'hFFFF_FFFF);
    run_frame(1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, -1, mism);
    chk(mism == 0, "R8", "repeat across frames, bad tick", 32'(first_bad), 32'hFFFF_FFFF);

    // R5 unexpected sync: latch and restart
    ctrl_word = mk_ctrl(0, 3, 0, 0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) push(32'h0000_00FF);
    feed();
    tick(1'b1, b);
    tick(1'b0, b);
    @(negedge clk);
    @(negedge clk);
    chk(sdata == 1'b1, "R11", "sdata held between ticks", 32'(sdata), 32'd1);
    for (int t = 2; t < 5; t++) tick(1'b0, b);
    tick(1'b1, b);
    chk(sync_err == 1'b1 && b == 1'b1, "R5", "mid-frame sync (err,bit)",
        {30'd0, sync_err, b}, 32'd3);
    acc = 32'd1;
    for (int t = 0; t < 31; t++) begin
      tick(1'b0, b);
      if (b == 1'b1) acc++;
    end
    chk(acc == 32'd32, "R5", "ones counted from restart", acc, 32'd32);
    tick(1'b0, b);
    chk(b == 1'b0, "R5", "restarted frame ends after 32 bits", 32'(b), 32'd0);
    chk(sync_err == 1'b1, "R5", "error stays latched", 32'(sync_err), 32'd1);

    // R10 disable mid-frame
    tick(1'b1, b);
    tick(1'b0, b);
    chk(b == 1'b1, "R8", "resent word before disable", 32'(b), 32'd1);
    tx_en = 1'b0;
    @(negedge clk);
    chk(sdata == 1'b0 && sync_err == 1'b0, "R10", "disable clears (sdata,err)",
        {30'd0, sdata, sync_err}, 32'd0);
    tick(1'b1, b);
    chk(b == 1'b0 && sync_err == 1'b0, "R10", "sync ignored while disabled",
        {30'd0, b, sync_err}, 32'd0);

    report();
  end
endmodule